// File: doc/BRIEF.md
# Burst-of-Two Synchronous SRAM Bus Cycle Engine

This block is the command and data front end of a synchronous static memory that transfers two words for every accepted command. Each clock cycle it samples an active-low load strobe, a read/write select and a word address. The lowest address bit picks which word of the aligned pair is moved first, and the other word of the pair always follows. The two edges of the double-rate data bus are modelled as two beat lanes per single-edge clock cycle: beat 0 is the first half of the cycle and beat 1 is the second half.

Write data and per-beat byte-lane enables arrive in the cycle after the write command. Read data leaves in the cycle after the read command, with an output-enable flag. A read of a word that is being written in that same cycle returns the new bytes, taken before the array is updated. The storage is an internal register array whose contents are undefined after reset.

Top module: `burst2_sram`

## Requirements
- R1: With `ld_n` high the cycle is a no-operation. `rw_sel` and `addr` are ignored, `rd_oe` is low in the next cycle, and the data inputs of the next cycle are not written anywhere.
- R2: With `ld_n` low, `rw_sel` = 1 starts a read and `rw_sel` = 0 starts a write. Every command moves exactly two words.
- R3: `addr[0]` is the burst start. Beat 0 uses word `addr`, and beat 1 uses the word with `addr[0]` inverted. A start of 0 gives the order 0,1 and a start of 1 gives 1,0.
- R4: Write data for a command accepted in cycle t is taken from `wdata0` (beat 0) and `wdata1` (beat 1) during cycle t+1.
- R5: Read data for a command accepted in cycle t appears during cycle t+1, beat 0 on `rdata0` and beat 1 on `rdata1`, with `rd_oe` high.
- R6: Byte enables are active low, one per 9-bit lane, and lane k covers bits 9k+8..9k. `be0_n` applies to beat 0 and `be1_n` to beat 1, independently.
- R7: A write with all enables high changes no stored byte. It still owns the data slot of the following cycle.
- R8: When a read is accepted in the cycle that carries a pending write's data, each read word whose full address equals a written word returns the newly enabled lanes merged over the stored ones.
- R9: While `rd_oe` is low, `rdata0` and `rdata1` are both zero, which stands for an undriven bus.
- R10: A command is accepted every cycle, including write after write and read after write, with no idle cycle between them.
- R11: Synchronous reset drops `rd_oe` and discards a pending write, so its data is never stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low command load strobe |
| rw_sel | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address; bit 0 is the burst start |
| be0_n | input | W/9 | Active-low lane enables, beat 0 |
| be1_n | input | W/9 | Active-low lane enables, beat 1 |
| wdata0 | input | W | Write data, beat 0 |
| wdata1 | input | W | Write data, beat 1 |
| rdata0 | output | W | Read data, beat 0 |
| rdata1 | output | W | Read data, beat 1 |
| rd_oe | output | 1 | Read data output enable |

## Verification
The whole array is first filled with address-derived words, so every later read has a known value and reads of both start bits on the same pair show whether the beat order wraps. Per-beat enable patterns that differ between beats, and the all-high pattern, separate lane decoding from beat selection. No-operation cycles carrying write-like data, and a reset placed between a write command and its data, show whether data without an owning command is stored. Reads placed right after writes test the forwarding path: with the same start bit, with the opposite start bit, and with only some lanes enabled, so that merged and stored lanes mix in one word.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

    localparam int B2S_LANE_W = 9;

    typedef enum logic [1:0] {
        B2S_IDLE  = 2'd0,
        B2S_READ  = 2'd1,
        B2S_WRITE = 2'd2
    } b2s_state_e;

endpackage

// File: rtl/b2s_array.sv
module b2s_array
    import b2s_pkg::*;
#(
    parameter int W  = 36,
    parameter int AW = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           wa,
    input  logic [W-1:0]            wd0,
    input  logic [W-1:0]            wd1,
    input  logic [W/B2S_LANE_W-1:0] be0_n,
    input  logic [W/B2S_LANE_W-1:0] be1_n,
    input  logic [AW-1:0]           ra,
    output logic [W-1:0]            arr0,
    output logic [W-1:0]            arr1
);
    localparam int LANES = W / B2S_LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wa_x;
    logic [AW-1:0] ra_x;

    assign wa_x = {wa[AW-1:1], ~wa[0]};
    assign ra_x = {ra[AW-1:1], ~ra[0]};

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (!be0_n[l]) mem[wa][l*B2S_LANE_W +: B2S_LANE_W] <= wd0[l*B2S_LANE_W +: B2S_LANE_W];
                if (!be1_n[l]) mem[wa_x][l*B2S_LANE_W +: B2S_LANE_W] <= wd1[l*B2S_LANE_W +: B2S_LANE_W];
            end
        end
    end

    assign arr0 = mem[ra];
    assign arr1 = mem[ra_x];

endmodule

// File: rtl/b2s_merge.sv
module b2s_merge
    import b2s_pkg::*;
#(
    parameter int W  = 36,
    parameter int AW = 8
) (
    input  logic                    fwd_en,
    input  logic [AW-1:0]           wa,
    input  logic [W-1:0]            wd0,
    input  logic [W-1:0]            wd1,
    input  logic [W/B2S_LANE_W-1:0] be0_n,
    input  logic [W/B2S_LANE_W-1:0] be1_n,
    input  logic [AW-1:0]           ra,
    input  logic [W-1:0]            arr0,
    input  logic [W-1:0]            arr1,
    output logic [W-1:0]            q0,
    output logic [W-1:0]            q1
);
    localparam int LANES = W / B2S_LANE_W;

    logic [AW-1:0]    w_adr [2];
    logic [AW-1:0]    r_adr [2];
    logic [W-1:0]     w_dat [2];
    logic [LANES-1:0] w_ben [2];
    logic [W-1:0]     r_in  [2];
    logic [W-1:0]     r_out [2];

    assign w_adr[0] = wa;
    assign w_adr[1] = {wa[AW-1:1], ~wa[0]};
    assign r_adr[0] = ra;
    assign r_adr[1] = {ra[AW-1:1], ~ra[0]};
    assign w_dat[0] = wd0;
    assign w_dat[1] = wd1;
    assign w_ben[0] = be0_n;
    assign w_ben[1] = be1_n;
    assign r_in[0]  = arr0;
    assign r_in[1]  = arr1;

    always_comb begin
        for (int k = 0; k < 2; k++) begin
            r_out[k] = r_in[k];
            for (int j = 0; j < 2; j++) begin
                if (fwd_en && (r_adr[k] == w_adr[j])) begin
                    for (int l = 0; l < LANES; l++) begin
                        if (!w_ben[j][l]) begin
                            r_out[k][l*B2S_LANE_W +: B2S_LANE_W] = w_dat[j][l*B2S_LANE_W +: B2S_LANE_W];
                        end
                    end
                end
            end
        end
    end

    assign q0 = r_out[0];
    assign q1 = r_out[1];

endmodule

// File: rtl/b2s_ctrl.sv
module b2s_ctrl
    import b2s_pkg::*;
#(
    parameter int W  = 36,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          rw_sel,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  look0,
    input  logic [W-1:0]  look1,
    output logic          wr_pend,
    output logic [AW-1:0] wr_addr,
    output logic          rd_oe,
    output logic [W-1:0]  rdata0,
    output logic [W-1:0]  rdata1
);
    typedef struct packed {
        b2s_state_e    st;
        logic [AW-1:0] adr;
        logic [W-1:0]  d0;
        logic [W-1:0]  d1;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.d0  = '0;
        ctl_d.d1  = '0;
        if (ld_n) begin
            ctl_d.st = B2S_IDLE;
        end else if (rw_sel) begin
            ctl_d.st  = B2S_READ;
            ctl_d.adr = addr;
            ctl_d.d0  = look0;
            ctl_d.d1  = look1;
        end else begin
            ctl_d.st  = B2S_WRITE;
            ctl_d.adr = addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign wr_pend = (ctl_q.st == B2S_WRITE);
    assign wr_addr = ctl_q.adr;
    assign rd_oe   = (ctl_q.st == B2S_READ);
    assign rdata0  = ctl_q.d0;
    assign rdata1  = ctl_q.d1;

endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
    import b2s_pkg::*;
#(
    parameter int W  = 36,
    parameter int AW = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_n,
    input  logic                    rw_sel,
    input  logic [AW-1:0]           addr,
    input  logic [W/B2S_LANE_W-1:0] be0_n,
    input  logic [W/B2S_LANE_W-1:0] be1_n,
    input  logic [W-1:0]            wdata0,
    input  logic [W-1:0]            wdata1,
    output logic [W-1:0]            rdata0,
    output logic [W-1:0]            rdata1,
    output logic                    rd_oe
);
    logic          wr_pend;
    logic [AW-1:0] wr_addr;
    logic          arr_we;
    logic [W-1:0]  arr0, arr1;
    logic [W-1:0]  look0, look1;

    assign arr_we = wr_pend & ~rst;

    b2s_ctrl #(.W(W), .AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel), .addr(addr),
        .look0(look0), .look1(look1), .wr_pend(wr_pend), .wr_addr(wr_addr),
        .rd_oe(rd_oe), .rdata0(rdata0), .rdata1(rdata1)
    );

    b2s_array #(.W(W), .AW(AW)) u_array (
        .clk(clk), .we(arr_we), .wa(wr_addr), .wd0(wdata0), .wd1(wdata1),
        .be0_n(be0_n), .be1_n(be1_n), .ra(addr), .arr0(arr0), .arr1(arr1)
    );

    b2s_merge #(.W(W), .AW(AW)) u_merge (
        .fwd_en(wr_pend), .wa(wr_addr), .wd0(wdata0), .wd1(wdata1),
        .be0_n(be0_n), .be1_n(be1_n), .ra(addr), .arr0(arr0), .arr1(arr1),
        .q0(look0), .q1(look1)
    );

endmodule

// File: rtl/b2s_checker.sv
module b2s_checker #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst,
    input logic         ld_n,
    input logic         rw_sel,
    input logic         rd_oe,
    input logic [W-1:0] rdata0,
    input logic [W-1:0] rdata1
);
    a_r1_nop_no_output: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> !rd_oe);

    a_r5_read_enables_output: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && rw_sel) |=> rd_oe);

    a_r2_write_no_output: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && !rw_sel) |=> !rd_oe);

    a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_oe |-> (rdata0 == '0 && rdata1 == '0));

    a_r11_reset_drops_oe: assert property (@(posedge clk)
        rst |=> !rd_oe);
endmodule

bind burst2_sram b2s_checker #(.W(W)) u_b2s_checker (
    .clk(clk), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel),
    .rd_oe(rd_oe), .rdata0(rdata0), .rdata1(rdata1)
);

// File: tb/tb_burst2_sram.sv
`timescale 1ns/1ps
module tb_burst2_sram;
    localparam int W  = 36;
    localparam int AW = 8;
    localparam int LN = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_n = 1'b1;
    logic          rw_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] be0_n = '1, be1_n = '1;
    logic [W-1:0]  wdata0 = '0, wdata1 = '0;
    logic [W-1:0]  rdata0, rdata1;
    logic          rd_oe;

    always #2.5 clk = ~clk;

    burst2_sram #(.W(W), .AW(AW)) dut (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel), .addr(addr),
        .be0_n(be0_n), .be1_n(be1_n), .wdata0(wdata0), .wdata1(wdata1),
        .rdata0(rdata0), .rdata1(rdata1), .rd_oe(rd_oe)
    );

    typedef struct packed {
        logic         oe;
        logic [W-1:0] d0;
        logic [W-1:0] d1;
    } exp_t;

    exp_t          exp_q[$];
    string         tag_q[$];
    logic [W-1:0]  mdl [1 << AW];
    logic          pend_v = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic [W-1:0]  nd0 = '0, nd1 = '0;
    logic [LN-1:0] nb0 = '1, nb1 = '1;
    int            n_run = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    function automatic logic [W-1:0] pat(input logic [AW-1:0] a, input logic [7:0] salt);
        return {4'hA, salt, a, a ^ 8'h5C, 8'(a * 3)};
    endfunction

    task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] flip(input logic [AW-1:0] a);
        return {a[AW-1:1], ~a[0]};
    endfunction

    // Driver: one command per cycle; w0/w1/b0/b1 belong to this command and go out next cycle.
    task automatic drive(input logic l_n, input logic rs, input logic [AW-1:0] a,
                         input logic [W-1:0] w0, input logic [W-1:0] w1,
                         input logic [LN-1:0] b0, input logic [LN-1:0] b1, input string tag);
        exp_t e;
        @(negedge clk); #1;
        ld_n = l_n; rw_sel = rs; addr = a;
        wdata0 = nd0; wdata1 = nd1; be0_n = nb0; be1_n = nb1;
        if (pend_v) begin
            for (int l = 0; l < LN; l++) begin
                if (!nb0[l]) mdl[pend_a][l*9 +: 9] = nd0[l*9 +: 9];
                if (!nb1[l]) mdl[flip(pend_a)][l*9 +: 9] = nd1[l*9 +: 9];
            end
        end
        pend_v = !l_n && !rs;
        pend_a = a;
        if (!l_n && rs) e = '{1'b1, mdl[a], mdl[flip(a)]};
        else            e = '{1'b0, '0, '0};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        nd0 = w0; nd1 = w1; nb0 = b0; nb1 = b1;
    endtask

    task automatic nop(input string tag);
        drive(1'b1, 1'b0, '0, '0, '0, '1, '1, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        drive(1'b0, 1'b1, a, '0, '0, '1, '1, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] w0, input logic [W-1:0] w1,
                      input logic [LN-1:0] b0, input logic [LN-1:0] b1, input string tag);
        drive(1'b0, 1'b0, a, w0, w1, b0, b1, tag);
    endtask

    task automatic reset_pulse();
        @(negedge clk); #1;
        rst = 1'b1; ld_n = 1'b1;
        wdata0 = nd0; wdata1 = nd1; be0_n = nb0; be1_n = nb1;
        pend_v = 1'b0;
        exp_q.push_back('{1'b0, '0, '0}); tag_q.push_back("R11");
        nd0 = '0; nd1 = '0; nb0 = '1; nb1 = '1;
        @(negedge clk); #1;
        rst = 1'b0; be0_n = '1; be1_n = '1;
        exp_q.push_back('{1'b0, '0, '0}); tag_q.push_back("R11");
    endtask

    // Monitor: pops one expected item per cycle and compares it with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "rd_oe", W'(rd_oe), W'(e.oe));
                chk(e.oe ? t : "R9", "rdata0", rdata0, e.d0);
                chk(e.oe ? t : "R9", "rdata1", rdata1, e.d1);
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset rd_oe", W'(rd_oe), '0);
        chk("R11", "reset rdata0", rdata0, '0);
        #1 rst = 1'b0;

        // R4/R2: fill every pair with start-0 writes
        for (int a = 0; a < (1 << AW); a += 2)
            wr(AW'(a), pat(AW'(a), 8'h01), pat(AW'(a + 1), 8'h01), '0, '0, "R4");
        nop("R1");

        // R5/R3: read order for both start bits, back to back
        rd(8'd4, "R5");
        rd(8'd5, "R3");
        rd(8'd200, "R10");

        // R3: write with start 1, read with start 0
        wr(8'd9, pat(8'd9, 8'h22), pat(8'd8, 8'h22), '0, '0, "R3");
        nop("R3");
        rd(8'd8, "R3");

        // R6: lanes differ per beat
        wr(8'd12, pat(8'd12, 8'h33), pat(8'd13, 8'h33), 4'b1010, 4'b0101, "R6");
        nop("R6");
        rd(8'd12, "R6");

        // R7: all enables high, then read same cycle as the data and later
        wr(8'd16, pat(8'd16, 8'h44), pat(8'd17, 8'h44), '1, '1, "R7");
        rd(8'd16, "R7");
        rd(8'd17, "R7");

        // R1: no-operation with write-like inputs and data
        drive(1'b1, 1'b0, 8'd20, pat(8'd20, 8'h55), pat(8'd21, 8'h55), '0, '0, "R1");
        drive(1'b1, 1'b1, 8'd22, '0, '0, '1, '1, "R1");
        rd(8'd20, "R1");

        // R8: forwarding, same start, opposite start, partial lanes
        wr(8'd30, pat(8'd30, 8'h66), pat(8'd31, 8'h66), '0, '0, "R8");
        rd(8'd30, "R8");
        wr(8'd40, pat(8'd40, 8'h77), pat(8'd41, 8'h77), '0, '0, "R8");
        rd(8'd41, "R8");
        wr(8'd51, pat(8'd51, 8'h88), pat(8'd50, 8'h88), 4'b0011, 4'b1100, "R8");
        rd(8'd50, "R8");

        // R10: write after write, read-write-read on one pair
        wr(8'd60, pat(8'd60, 8'h99), pat(8'd61, 8'h99), '0, '0, "R10");
        wr(8'd63, pat(8'd63, 8'hAA), pat(8'd62, 8'hAA), '0, 4'b0110, "R10");
        rd(8'd60, "R10");
        rd(8'd62, "R10");
        rd(8'd70, "R10");
        wr(8'd70, pat(8'd70, 8'hBB), pat(8'd71, 8'hBB), '0, '0, "R10");
        rd(8'd71, "R10");

        // R11: reset between a write command and its data
        wr(8'd80, pat(8'd80, 8'hCC), pat(8'd81, 8'hCC), '0, '0, "R11");
        reset_pulse();
        rd(8'd80, "R11");
        nop("R9");
        nop("R9");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule